// File: doc/BRIEF.md
# Protection Key Rights Check Unit

This unit decides whether a data access whose address has already been translated must fault because of protection-key rights. It receives the 4-bit key from the leaf page-table entry, the user/supervisor flag of every paging level, the access type (fetch, user, write), the present and reserved-bit status of the walk, and two 32-bit rights registers. The user rights register serves user-mode addresses and the supervisor rights register serves supervisor-mode addresses. Each register holds a two-bit entry per key: access-disable in the low bit, write-disable in the high bit.

The policy inputs are long-mode active, a user-address key enable, a supervisor-address key enable and write-protect. They are folded into a 16-entry, 2-bit mask when a control write strobe arrives. Each check then costs one mask lookup, one AND against the selected rights pair and one register stage. The check result comes back one cycle after the request, together with a one-cycle valid strobe.

Top module: `pkey_guard`

## Requirements
- R1: For key k, the selected pair is bits 2k (access-disable) and 2k+1 (write-disable) of the chosen rights register, and it is reported on `res_rights` as {write-disable, access-disable}.
- R2: An address is user-mode only when every bit of `walk_us` is 1. A user-mode address uses `rights_user` and any other address uses `rights_sup`, whatever the value of `acc_user`.
- R3: A request with `acc_fetch`=1 never sets `res_fault`.
- R4: A request with `walk_present`=0 or `walk_rsvd`=1 never sets `res_fault`.
- R5: When the long-mode bit of the last control write is 0, no request faults.
- R6: A user-mode address can fault only if the user-address enable is 1, and a supervisor-mode address can fault only if the supervisor-address enable is 1.
- R7: A data access faults when its selected access-disable bit is 1 and checks are enabled for it.
- R8: The write-disable bit causes a fault only on writes. For user accesses it always applies. For supervisor accesses (`acc_user`=0) it applies only when write-protect is 1.
- R9: Control values take effect for requests issued in the cycles after the `ctl_wr` edge. A request at the same edge uses the previous policy. After reset, and before any control write, no request faults.
- R10: `res_valid` is high for exactly the one cycle after each request cycle. Reset clears `res_valid` and `res_fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control write strobe; rebuilds the mask |
| ctl_lma | input | 1 | Long mode active |
| ctl_uen | input | 1 | Key checks enabled for user-mode addresses |
| ctl_sen | input | 1 | Key checks enabled for supervisor-mode addresses |
| ctl_wp | input | 1 | Write-protect for supervisor accesses |
| chk_valid | input | 1 | Check request |
| pte_key | input | 4 | Protection key from the leaf entry |
| walk_us | input | LEVELS | User/supervisor flag per paging level (unused levels driven 1) |
| walk_present | input | 1 | Translation present |
| walk_rsvd | input | 1 | Reserved bit hit during the walk |
| acc_fetch | input | 1 | Access is an instruction fetch |
| acc_user | input | 1 | Access made in user mode |
| acc_write | input | 1 | Access is a write |
| rights_user | input | 32 | Rights register for user-mode addresses |
| rights_sup | input | 32 | Rights register for supervisor-mode addresses |
| res_valid | output | 1 | Result strobe, one cycle after a request |
| res_fault | output | 1 | Protection-key fault |
| res_rights | output | 2 | Selected {write-disable, access-disable} pair |

## Verification
The hardest situation to reach is a request where the access mode and the address mode disagree. One case is a supervisor write to a user-mode address with write-protect clear. The other is a user access to a supervisor-mode address. In both cases only the choice of register and the write-protect mask decide the result. The stimulus loads the two rights registers with complementary pairs at the tested key, so selecting the wrong register or the wrong bit position flips both the fault and the reported pair. It also issues a request on the same edge as a control write, which shows whether the old or the new mask was used.

// File: rtl/pkey_pkg.sv
package pkey_pkg;
  localparam int KEY_W    = 4;
  localparam int NUM_KEYS = 1 << KEY_W;
  localparam int RIGHTS_W = 2 * NUM_KEYS;
  localparam int IDX_W    = 4;
  localparam int MASK_N   = 1 << IDX_W;

  typedef struct packed {
    logic lma;
    logic uen;
    logic sen;
    logic wp;
  } pk_ctl_t;

  // mask index layout: {fetch, address user-mode, access user-mode, write}
  typedef struct packed {
    logic fetch;
    logic addr_user;
    logic acc_user;
    logic write;
  } pk_idx_t;
endpackage

// File: rtl/pkey_mask_gen.sv
module pkey_mask_gen
  import pkey_pkg::*;
#(
  parameter int N_ENT = MASK_N
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ctl_wr,
  input  pk_ctl_t                  ctl,
  input  logic [$clog2(N_ENT)-1:0] rd_idx,
  output logic [1:0]               rd_entry
);
  localparam int IW = $clog2(N_ENT);

  logic [N_ENT-1:0][1:0] nxt;
  logic [N_ENT-1:0][1:0] mask_q;

  genvar e;
  generate
    for (e = 0; e < N_ENT; e++) begin : g_ent
      localparam logic [IW-1:0] I = IW'(e);
      logic en;
      // fetch slots stay empty; address class picks its enable
      assign en = ctl.lma & ~I[3] & (I[2] ? ctl.uen : ctl.sen);
      assign nxt[e] = {en & I[0] & (I[1] | ctl.wp), en};

      // R6
      user_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && I[2] && !ctl.uen) |=> (mask_q[e] == 2'b00));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
    end else if (ctl_wr) begin
      mask_q <= nxt;
    end
  end

  assign rd_entry = mask_q[rd_idx];

  // R5
  lma_off_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && !ctl.lma) |=> ($countones(mask_q) == 0));
endmodule

// File: rtl/pkey_rights_sel.sv
module pkey_rights_sel
  import pkey_pkg::*;
#(
  parameter int LEVELS = 5,
  parameter int KW     = KEY_W
) (
  input  logic [LEVELS-1:0]    walk_us,
  input  logic [KW-1:0]        key,
  input  logic [2*(1<<KW)-1:0] rights_user,
  input  logic [2*(1<<KW)-1:0] rights_sup,
  output logic                 addr_user,
  output logic [1:0]           pair
);
  logic [2*(1<<KW)-1:0] reg_sel;

  assign addr_user = &walk_us;
  assign reg_sel   = addr_user ? rights_user : rights_sup;
  assign pair      = reg_sel[{key, 1'b0} +: 2];
endmodule

// File: rtl/pkey_verdict.sv
module pkey_verdict (
  input  logic       clk,
  input  logic       rst,
  input  logic       chk_valid,
  input  logic       walk_present,
  input  logic       walk_rsvd,
  input  logic [1:0] mask_entry,
  input  logic [1:0] pair,
  output logic       res_valid,
  output logic       res_fault,
  output logic [1:0] res_rights
);
  logic terminal;
  logic fault_c;

  assign terminal = ~walk_present | walk_rsvd;
  assign fault_c  = ~terminal & |(mask_entry & pair);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_fault  <= 1'b0;
      res_rights <= 2'b00;
    end else begin
      res_valid <= chk_valid;
      res_fault <= chk_valid & fault_c;
      if (chk_valid) res_rights <= pair;
    end
  end

  // R4
  terminal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && terminal) |=> !res_fault);

  // R10
  strobe_chk: assert property (@(posedge clk) disable iff (rst)
    chk_valid |=> res_valid);
endmodule

// File: rtl/pkey_guard.sv
module pkey_guard
  import pkey_pkg::*;
#(
  parameter int LEVELS = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ctl_wr,
  input  logic                ctl_lma,
  input  logic                ctl_uen,
  input  logic                ctl_sen,
  input  logic                ctl_wp,
  input  logic                chk_valid,
  input  logic [KEY_W-1:0]    pte_key,
  input  logic [LEVELS-1:0]   walk_us,
  input  logic                walk_present,
  input  logic                walk_rsvd,
  input  logic                acc_fetch,
  input  logic                acc_user,
  input  logic                acc_write,
  input  logic [RIGHTS_W-1:0] rights_user,
  input  logic [RIGHTS_W-1:0] rights_sup,
  output logic                res_valid,
  output logic                res_fault,
  output logic [1:0]          res_rights
);
  pk_ctl_t    ctl;
  pk_idx_t    idx;
  logic       addr_user;
  logic [1:0] pair;
  logic [1:0] mask_entry;

  assign ctl = '{lma: ctl_lma, uen: ctl_uen, sen: ctl_sen, wp: ctl_wp};
  assign idx = '{fetch: acc_fetch, addr_user: addr_user,
                 acc_user: acc_user, write: acc_write};

  pkey_rights_sel #(.LEVELS(LEVELS), .KW(KEY_W)) u_sel (
    .walk_us     (walk_us),
    .key         (pte_key),
    .rights_user (rights_user),
    .rights_sup  (rights_sup),
    .addr_user   (addr_user),
    .pair        (pair)
  );

  pkey_mask_gen #(.N_ENT(MASK_N)) u_mask (
    .clk      (clk),
    .rst      (rst),
    .ctl_wr   (ctl_wr),
    .ctl      (ctl),
    .rd_idx   (idx),
    .rd_entry (mask_entry)
  );

  pkey_verdict u_verdict (
    .clk          (clk),
    .rst          (rst),
    .chk_valid    (chk_valid),
    .walk_present (walk_present),
    .walk_rsvd    (walk_rsvd),
    .mask_entry   (mask_entry),
    .pair         (pair),
    .res_valid    (res_valid),
    .res_fault    (res_fault),
    .res_rights   (res_rights)
  );

  // R3
  fetch_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && acc_fetch) |=> !res_fault);

  // R1
  fault_needs_bit_chk: assert property (@(posedge clk) disable iff (rst)
    res_fault |-> (res_rights != 2'b00));

  // R10
  no_stray_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !chk_valid |=> !res_valid);
endmodule

// File: tb/sim_pkey_guard.sv
module sim_pkey_guard;
  localparam int LV = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_wr = 0, ctl_lma = 0, ctl_uen = 0, ctl_sen = 0, ctl_wp = 0;
  logic chk_valid = 0;
  logic [3:0] pte_key = '0;
  logic [LV-1:0] walk_us = '1;
  logic walk_present = 1, walk_rsvd = 0;
  logic acc_fetch = 0, acc_user = 0, acc_write = 0;
  logic [31:0] rights_user = '0, rights_sup = '0;
  logic res_valid, res_fault;
  logic [1:0] res_rights;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pkey_guard #(.LEVELS(LV)) u0 (.*);

  // fields: [20:17] {lma,uen,sen,wp} [16:13] key [12] addr user [11] fetch
  // [10] acc user [9] write [8] present [7] rsvd [6] AD [5] WD [4] fault [3:0] req
  localparam int NV = 17;
  localparam logic [20:0] VEC [NV] = '{
    21'b1111_0011_1_0_1_0_1_0_1_0_1_0111, // R7 AD on user read
    21'b1111_0101_1_0_1_1_1_0_0_1_1_1000, // R8 WD on user write
    21'b1111_0101_1_0_1_0_1_0_0_1_0_1000, // R8 WD ignored on read
    21'b1111_0010_0_0_0_1_1_0_0_1_1_1000, // R8 sup write, wp=1
    21'b1110_0010_0_0_0_1_1_0_0_1_0_1000, // R8 sup write, wp=0
    21'b1110_0010_0_0_0_0_1_0_1_0_1_1000, // R8 AD kept with wp=0
    21'b1111_0111_1_1_1_0_1_0_1_1_0_0011, // R3 fetch
    21'b1111_0001_1_0_1_0_0_0_1_0_0_0100, // R4 not present
    21'b1111_0001_1_0_1_0_1_1_1_0_0_0100, // R4 reserved bit
    21'b0111_0100_1_0_1_0_1_0_1_0_0_0101, // R5 long mode off
    21'b1011_0100_1_0_1_0_1_0_1_0_0_0110, // R6 user enable off
    21'b1011_0100_0_0_1_0_1_0_1_0_1_0110, // R6 sup address still checked
    21'b1101_0100_0_0_1_0_1_0_1_0_0_0110, // R6 sup enable off
    21'b1111_1111_1_0_0_0_1_0_1_0_1_0010, // R2 sup access, user address
    21'b1111_0000_0_0_1_0_1_0_0_0_0_0010, // R2 user access, sup address
    21'b1110_1001_1_0_0_1_1_0_0_1_0_1000, // R8 sup write user addr wp=0
    21'b1111_1001_1_0_0_1_1_0_0_1_1_1000  // R8 same with wp=1
  };

  task automatic chk(input bit ok, input int req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic put_ctl(input logic [3:0] c);
    @(negedge clk);
    {ctl_lma, ctl_uen, ctl_sen, ctl_wp} = c;
    ctl_wr = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  // sets rights so the chosen register holds {wd,ad} at key and the other
  // register holds the complement there; drives one request
  task automatic issue(input logic [3:0] key, input bit au, input bit f,
                       input bit u, input bit w, input bit p, input bit r,
                       input bit ad, input bit wd, input bit same_edge_ctl);
    logic [31:0] sel, oth;
    sel = 32'h5555_5555 ^ {16{~wd, ~ad}};
    oth = ~sel;
    sel[{key, 1'b0} +: 2] = {wd, ad};
    oth[{key, 1'b0} +: 2] = ~{wd, ad};
    if (!same_edge_ctl) @(negedge clk);
    rights_user = au ? sel : oth;
    rights_sup  = au ? oth : sel;
    walk_us = '1;
    if (!au) walk_us[key % LV] = 1'b0;
    pte_key = key;
    acc_fetch = f; acc_user = u; acc_write = w;
    walk_present = p; walk_rsvd = r;
    chk_valid = 1'b1;
    @(negedge clk);
    chk_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R10 watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk(res_valid == 1'b0, 10, "valid after reset", res_valid, 0);
    chk(res_fault == 1'b0, 10, "fault after reset", res_fault, 0);

    // R9 no control write yet: mask empty
    issue(4'd6, 1'b1, 0, 1, 1, 1, 0, 1'b1, 1'b1, 1'b0);
    chk(res_valid == 1'b1, 10, "valid after request", res_valid, 1);
    chk(res_fault == 1'b0, 9, "fault before control write", res_fault, 0);
    chk(res_rights == 2'b11, 1, "pair before control write", res_rights, 3);
    @(negedge clk);
    chk(res_valid == 1'b0, 10, "valid one cycle only", res_valid, 0);

    for (int i = 0; i < NV; i++) begin
      logic [20:0] v;
      v = VEC[i];
      put_ctl(v[20:17]);
      issue(v[16:13], v[12], v[11], v[10], v[9], v[8], v[7], v[6], v[5], 1'b0);
      chk(res_valid == 1'b1, 10, "valid", res_valid, 1);
      chk(res_fault == v[4], int'(v[3:0]), $sformatf("fault vec %0d", i),
          res_fault, v[4]);
      chk(res_rights == {v[5], v[6]}, 1, $sformatf("pair vec %0d", i),
          res_rights, {v[5], v[6]});
    end

    // R9 request on the same edge as a control write uses the old policy
    put_ctl(4'b1111);
    @(negedge clk);
    {ctl_lma, ctl_uen, ctl_sen, ctl_wp} = 4'b0111;
    ctl_wr = 1'b1;
    issue(4'd12, 1'b1, 0, 1, 0, 1, 0, 1'b1, 1'b0, 1'b1);
    ctl_wr = 1'b0;
    chk(res_fault == 1'b1, 9, "same-edge uses old mask", res_fault, 1);
    issue(4'd12, 1'b1, 0, 1, 0, 1, 0, 1'b1, 1'b0, 1'b0);
    chk(res_fault == 1'b0, 9, "next request uses new mask", res_fault, 0);

    // R10 reset clears result
    put_ctl(4'b1111);
    issue(4'd3, 1'b1, 0, 1, 0, 1, 0, 1'b1, 1'b0, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    chk(res_valid == 1'b0 && res_fault == 1'b0, 10, "reset clears",
        {res_valid, res_fault}, 0);
    rst = 1'b0;
    // R9 reset empties mask again
    issue(4'd3, 1'b1, 0, 1, 0, 1, 0, 1'b1, 1'b0, 1'b0);
    chk(res_fault == 1'b0, 9, "mask cleared by reset", res_fault, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule